// File: doc/BRIEF.md
# Push-Button Switch with Idle Timeout

This block is a two-mode controller, off and on, driven by a single press bit. The press bit is read once per clock cycle, and each cycle counts as one round. A press while off turns the switch on. While the switch is on, an internal counter advances on every round that has no press. The switch drops back to off in two cases: on a second press, or once the counter has reached a configurable limit. Entering off clears the counter.

The mode and the counter are both brought out so that the surrounding logic can observe them. A second registered copy of the mode is also provided, intended to drive a load directly. The press input is assumed to be clean already: one bit per round, with no debouncing or edge detection inside the block.

Top module: `auto_off_switch`

## Requirements
- R1: A high `rst_i` at a clock edge forces the mode to off (`mode_o`=0) and the count to 0 after that edge, whatever the value of `press_i`.
- R2: While off, a round with `press_i`=0 keeps the mode off and leaves `count_o` unchanged.
- R3: While off, a round with `press_i`=1 switches the mode to on (`mode_o`=1) with `count_o` equal to 0.
- R4: While on, a round with `press_i`=0 and `count_o` below `LIMIT` keeps the mode on and raises `count_o` by exactly 1.
- R5: While on, a round with `press_i`=1 switches the mode to off and clears `count_o` to 0.
- R6: While on, an idle round with `count_o` equal to `LIMIT` switches the mode to off with count 0. After a press from off, the idle rounds therefore show counts 0,1,…,`LIMIT` and then off.
- R7: While on, a press in a round where `count_o` is at `LIMIT` causes a single transition to off with count 0. The mode does not return to on.
- R8: `count_o` never exceeds `LIMIT`, and it is 0 whenever the mode is off.
- R9: `on_o` equals `mode_o` on every cycle. The mode encoding is 0 for off and 1 for on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one round per rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| press_i | input | 1 | Press request for the current round |
| mode_o | output | 1 | Current mode, 0 off, 1 on |
| on_o | output | 1 | Registered copy of the mode for driving a load |
| count_o | output | $clog2(LIMIT+1) | Idle-round counter |

## Verification
Every cycle, the assertions check the single-round transition rules: off-idle, off-press, on-idle, on-press and timeout. They also check the counter bound, the zero count while off, and that `on_o` agrees with the mode. Only the bench scenarios can show the following:
- the complete 0 to `LIMIT` idle walk followed by expiry;
- a press landing exactly on the limit round;
- reset taking priority over a press, both while off and in the middle of an on period.

// File: rtl/auto_off_switch_pkg.sv
package auto_off_switch_pkg;

    typedef enum logic {
        SW_OFF = 1'b0,
        SW_ON  = 1'b1
    } sw_mode_e;

endpackage

// File: rtl/auto_off_switch_expire.sv
module auto_off_switch_expire #(
    parameter int LIMIT = 10,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic             expired_o
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    // Greater-or-equal keeps the rule safe even for an unreachable count.
    always_comb begin
        expired_o = (cnt_i >= LIM_V);
    end
endmodule

// File: rtl/auto_off_switch_step.sv
module auto_off_switch_step
    import auto_off_switch_pkg::*;
#(
    parameter int LIMIT = 10,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  sw_mode_e         mode_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             press_i,
    input  logic             expired_i,
    output sw_mode_e         mode_o,
    output logic [CNT_W-1:0] cnt_o
);
    // One transition per round; press and expiry together still yield off.
    always_comb begin
        mode_o = mode_i;
        cnt_o  = cnt_i;
        unique case (mode_i)
            SW_OFF: begin
                if (press_i) begin
                    mode_o = SW_ON;
                    cnt_o  = '0;
                end
            end
            SW_ON: begin
                if (press_i || expired_i) begin
                    mode_o = SW_OFF;
                    cnt_o  = '0;
                end else begin
                    cnt_o = cnt_i + 1'b1;
                end
            end
            default: begin
                mode_o = SW_OFF;
                cnt_o  = '0;
            end
        endcase
    end
endmodule

// File: rtl/auto_off_switch.sv
module auto_off_switch
    import auto_off_switch_pkg::*;
#(
    parameter int LIMIT = 10,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             press_i,
    output logic             mode_o,
    output logic             on_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        sw_mode_e         mode;
        logic             on;
        logic [CNT_W-1:0] cnt;
    } sw_state_t;

    sw_state_t        state_d;
    sw_state_t        state_q;
    logic             expired;
    sw_mode_e         step_mode;
    logic [CNT_W-1:0] step_cnt;

    auto_off_switch_expire #(.LIMIT(LIMIT)) expire_i (
        .cnt_i     (state_q.cnt),
        .expired_o (expired)
    );

    auto_off_switch_step #(.LIMIT(LIMIT)) step_i (
        .mode_i    (state_q.mode),
        .cnt_i     (state_q.cnt),
        .press_i   (press_i),
        .expired_i (expired),
        .mode_o    (step_mode),
        .cnt_o     (step_cnt)
    );

    always_comb begin
        if (rst_i) begin
            state_d.mode = SW_OFF;
            state_d.on   = 1'b0;
            state_d.cnt  = '0;
        end else begin
            state_d.mode = step_mode;
            state_d.on   = (step_mode == SW_ON);
            state_d.cnt  = step_cnt;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign mode_o  = state_q.mode;
    assign on_o    = state_q.on;
    assign count_o = state_q.cnt;
endmodule

// File: rtl/auto_off_switch_chk.sv
module auto_off_switch_chk #(
    parameter int LIMIT = 10,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             press_i,
    input logic             mode_o,
    input logic             on_o,
    input logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mode_o && !press_i) |=> (!mode_o && $stable(count_o))); // R2
    AST_OFF_PRESS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mode_o && press_i) |=> (mode_o && count_o == '0)); // R3
    AST_ON_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o && !press_i && count_o < LIM_V)
        |=> (mode_o && count_o == CNT_W'($past(count_o) + 1'b1))); // R4
    AST_ON_PRESS: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o && press_i) |=> (!mode_o && count_o == '0)); // R5
    AST_TIMEOUT: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o && count_o >= LIM_V) |=> (!mode_o && count_o == '0)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        count_o <= LIM_V); // R8
    AST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !mode_o |-> count_o == '0); // R8
    AST_MIRROR: assert property (@(posedge clk_i) disable iff (rst_i)
        on_o == mode_o); // R9
endmodule

bind auto_off_switch auto_off_switch_chk #(.LIMIT(LIMIT)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .press_i (press_i),
    .mode_o  (mode_o),
    .on_o    (on_o),
    .count_o (count_o)
);

// File: tb/auto_off_switch_tb_top.sv
`timescale 1ns/1ps
module auto_off_switch_tb_top;
    localparam int LIM = 10;
    localparam int CW  = $clog2(LIM + 1);

    typedef struct {
        bit    mode;
        int    cnt;
        string tag;
    } exp_t;

    logic          clk_i = 1'b0;
    logic          rst_i = 1'b1;
    logic          press_i = 1'b0;
    logic          mode_o;
    logic          on_o;
    logic [CW-1:0] count_o;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   ref_mode = 1'b0;
    int   ref_cnt  = 0;
    bit   done     = 1'b0;
    exp_t exp_q[$];

    always #2.5 clk_i = ~clk_i;

    auto_off_switch #(.LIMIT(LIM)) dut_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .press_i (press_i),
        .mode_o  (mode_o),
        .on_o    (on_o),
        .count_o (count_o)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: applies one round and pushes the expected result.
    task automatic round(bit rst, bit p, string tag);
        exp_t it;
        @(negedge clk_i);
        rst_i   = rst;
        press_i = p;
        if (rst) begin
            ref_mode = 1'b0;
            ref_cnt  = 0;
        end else if (!ref_mode) begin
            if (p) begin
                ref_mode = 1'b1;
                ref_cnt  = 0;
            end
        end else if (p || ref_cnt >= LIM) begin
            ref_mode = 1'b0;
            ref_cnt  = 0;
        end else begin
            ref_cnt++;
        end
        it.mode = ref_mode;
        it.cnt  = ref_cnt;
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compares after each edge.
    initial begin
        forever begin
            @(posedge clk_i);
            #1;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                check(mode_o == it.mode, {it.tag, " mode"}, int'(mode_o), int'(it.mode));
                check(int'(count_o) == it.cnt, {it.tag, " count"}, int'(count_o), it.cnt);
                check(on_o == mode_o, "R9 on_o mirror", int'(on_o), int'(mode_o));
                check(int'(count_o) <= LIM, "R8 bound", int'(count_o), LIM);
            end
        end
    end

    initial begin
        round(1'b1, 1'b1, "R1 reset with press");
        round(1'b1, 1'b0, "R1 reset");
        for (int i = 0; i < 3; i++) round(1'b0, 1'b0, "R2 off idle");
        round(1'b0, 1'b1, "R3 off press");
        for (int i = 0; i < 4; i++) round(1'b0, 1'b0, "R4 on idle");
        round(1'b0, 1'b1, "R5 on press");
        round(1'b0, 1'b0, "R2 off idle after press");
        round(1'b0, 1'b1, "R3 press again");
        for (int i = 0; i < LIM; i++) round(1'b0, 1'b0, "R4 walk to limit");
        round(1'b0, 1'b0, "R6 timeout");
        round(1'b0, 1'b0, "R2 stays off");
        round(1'b0, 1'b1, "R3 press");
        for (int i = 0; i < LIM; i++) round(1'b0, 1'b0, "R4 walk");
        round(1'b0, 1'b1, "R7 press at limit");
        round(1'b0, 1'b0, "R7 stays off");
        round(1'b0, 1'b1, "R3 press");
        round(1'b0, 1'b0, "R4 idle");
        round(1'b1, 1'b1, "R1 reset while on");
        round(1'b0, 1'b0, "R2 idle after reset");
        repeat (3) @(posedge clk_i);
        #2;
        check(exp_q.size() == 0, "monitor drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk_i);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule